// File: doc/BRIEF.md
# Commit-Time Late Operand Forwarder

This block lets a reorder buffer work without any read ports for source operands. When an instruction is dispatched, it cannot fetch a finished-but-uncommitted result from the reorder buffer, so it waits in the issue queue. When the producing entry retires, this block places the retired value and its physical tag on the same result buses that the execution units use. Waiting consumers then pick it up through their ordinary tag comparators, just as they would for a normal writeback.

Each cycle the block receives up to W retiring entries and the execution-unit writeback requests. Each retiring entry carries valid, a consumers-waiting flag, a tag and a value. Execution-unit writebacks are granted buses first, in index order. Any buses left over go to retiring entries whose consumers-waiting flag is set, in commit-slot order. Entries that find no free bus are kept in an internal hold stage. They are retried in later cycles, and the retire port reports not-ready until every held entry has been broadcast.

Top module: `commit_late_fwd`

## Requirements
- R1: After reset, no bus is driven, no grant is given and `cm_ready` is 1.
- R2: Requesting execution units are granted in ascending index order, up to NBUS of them. The k-th granted unit drives bus k with its tag and data, and `bus_late[k]`=0.
- R3: A late broadcast uses only buses that no execution unit was granted in that cycle. It never takes a bus while a requesting execution unit goes ungranted.
- R4: Only a retiring entry with both valid and consumers-waiting set is broadcast. An entry that lacks either flag never appears on a bus.
- R5: Late broadcasts fill the free buses in ascending order, starting right above the last granted execution-unit bus, and take entries in ascending commit-slot order. Each carries the entry's tag and data, with `bus_late`=1.
- R6: If any entry that qualified under R4 is not broadcast in its retire cycle, `cm_ready` is 0 from the next cycle on. While `cm_ready` is 0, the retire inputs are ignored: nothing presented there is ever broadcast.
- R7: Held entries are broadcast on later cycles by the rules of R3 and R5, in slot order. Every qualifying entry is broadcast exactly once.
- R8: `cm_ready` returns to 1 in the cycle after the last held entry is broadcast. With no execution-unit traffic, that takes ceil(held/NBUS) stalled cycles.
- R9: Reset discards held entries and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eu_req | input | NEU | Writeback request per execution unit |
| eu_tag | input | NEU×TAGW | Destination tag per execution unit |
| eu_data | input | NEU×DATAW | Result value per execution unit |
| eu_gnt | output | NEU | Bus granted to the execution unit this cycle |
| cm_valid | input | W | Retiring entry present, per commit slot |
| cm_pend | input | W | Consumers are waiting on this entry |
| cm_tag | input | W×TAGW | Physical tag of the retiring entry |
| cm_data | input | W×DATAW | Value of the retiring entry |
| cm_ready | output | 1 | Retire group accepted this cycle |
| bus_valid | output | NBUS | Bus carries a result |
| bus_late | output | NBUS | Bus carries a commit-time rebroadcast |
| bus_tag | output | NBUS×TAGW | Tag on each bus |
| bus_data | output | NBUS×DATAW | Value on each bus |

## Verification
The bench builds the block with W=4, NEU=4 and NBUS=3. With four execution units, writebacks alone can take every bus, so late entries can be starved outright. With four retire slots against three buses, a single retire group can overflow the buses even when no execution unit is active. Both paths into the hold stage are therefore exercised, and so is a stall that lasts several cycles under saturating writeback traffic. Per-tag delivery counts confirm that each waiting value arrives exactly once, and that inputs presented during a stall never arrive at all.

// File: rtl/lf_pkg.sv
package lf_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EU   = 2'd1,
        SRC_LATE = 2'd2
    } lf_src_e;
endpackage

// File: rtl/lf_eu_arb.sv
module lf_eu_arb #(
    parameter int NEU   = 4,
    parameter int NBUS  = 3,
    parameter int TAGW  = 6,
    parameter int DATAW = 16,
    parameter int CW    = 4
) (
    input  logic [NEU-1:0]              req,
    input  logic [NEU-1:0][TAGW-1:0]    tag,
    input  logic [NEU-1:0][DATAW-1:0]   data,
    output logic [NEU-1:0]              gnt,
    output logic [CW-1:0]               used,
    output logic [NBUS-1:0]             bv,
    output logic [NBUS-1:0][TAGW-1:0]   btag,
    output logic [NBUS-1:0][DATAW-1:0]  bdata
);
    logic [NEU-1:0][CW-1:0] rank;

    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NEU; i++) begin
            rank[i] = acc;
            gnt[i]  = req[i] && (acc < CW'(NBUS));
            if (req[i]) acc = acc + CW'(1);
        end
        used = (acc < CW'(NBUS)) ? acc : CW'(NBUS);
    end

    always_comb begin
        bv    = '0;
        btag  = '0;
        bdata = '0;
        for (int k = 0; k < NBUS; k++) begin
            for (int i = 0; i < NEU; i++) begin
                if (gnt[i] && rank[i] == CW'(k)) begin
                    bv[k]    = 1'b1;
                    btag[k]  = tag[i];
                    bdata[k] = data[i];
                end
            end
        end
    end
endmodule

// File: rtl/lf_late_pick.sv
module lf_late_pick #(
    parameter int W     = 4,
    parameter int NBUS  = 3,
    parameter int TAGW  = 6,
    parameter int DATAW = 16,
    parameter int CW    = 4
) (
    input  logic [W-1:0]                cand,
    input  logic [W-1:0][TAGW-1:0]      cand_tag,
    input  logic [W-1:0][DATAW-1:0]     cand_data,
    input  logic [CW-1:0]               start,
    output logic [W-1:0]                sent,
    output logic [NBUS-1:0]             bv,
    output logic [NBUS-1:0][TAGW-1:0]   btag,
    output logic [NBUS-1:0][DATAW-1:0]  bdata
);
    logic [W-1:0][CW-1:0] slot_bus;

    // Slot j goes to the next free bus above the writeback buses.
    always_comb begin
        logic [CW-1:0] acc;
        acc = start;
        for (int j = 0; j < W; j++) begin
            slot_bus[j] = acc;
            sent[j]     = cand[j] && (acc < CW'(NBUS));
            if (cand[j]) acc = acc + CW'(1);
        end
    end

    always_comb begin
        bv    = '0;
        btag  = '0;
        bdata = '0;
        for (int k = 0; k < NBUS; k++) begin
            for (int j = 0; j < W; j++) begin
                if (sent[j] && slot_bus[j] == CW'(k)) begin
                    bv[k]    = 1'b1;
                    btag[k]  = cand_tag[j];
                    bdata[k] = cand_data[j];
                end
            end
        end
    end
endmodule

// File: rtl/lf_hold_stage.sv
module lf_hold_stage #(
    parameter int W     = 4,
    parameter int TAGW  = 6,
    parameter int DATAW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [W-1:0]                cm_valid,
    input  logic [W-1:0]                cm_pend,
    input  logic [W-1:0][TAGW-1:0]      cm_tag,
    input  logic [W-1:0][DATAW-1:0]     cm_data,
    input  logic [W-1:0]                sent,
    output logic [W-1:0]                cand,
    output logic [W-1:0][TAGW-1:0]      cand_tag,
    output logic [W-1:0][DATAW-1:0]     cand_data,
    output logic                        cm_ready
);
    typedef struct packed {
        logic [W-1:0]             pend;
        logic [W-1:0][TAGW-1:0]   tag;
        logic [W-1:0][DATAW-1:0]  data;
    } hold_t;

    hold_t st_q, st_d;
    logic  busy;

    always_comb begin
        busy      = |st_q.pend;
        cm_ready  = !busy;
        cand      = busy ? st_q.pend : (cm_valid & cm_pend);
        cand_tag  = busy ? st_q.tag  : cm_tag;
        cand_data = busy ? st_q.data : cm_data;
        st_d.pend = cand & ~sent;
        st_d.tag  = cand_tag;
        st_d.data = cand_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: while entries are held, no new entry joins the held set.
    p_held_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.pend) |=> ((st_q.pend & ~$past(st_q.pend)) == '0));
endmodule

// File: rtl/commit_late_fwd.sv
module commit_late_fwd #(
    parameter int W     = 4,
    parameter int NEU   = 4,
    parameter int NBUS  = 3,
    parameter int TAGW  = 6,
    parameter int DATAW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NEU-1:0]              eu_req,
    input  logic [NEU-1:0][TAGW-1:0]    eu_tag,
    input  logic [NEU-1:0][DATAW-1:0]   eu_data,
    output logic [NEU-1:0]              eu_gnt,
    input  logic [W-1:0]                cm_valid,
    input  logic [W-1:0]                cm_pend,
    input  logic [W-1:0][TAGW-1:0]      cm_tag,
    input  logic [W-1:0][DATAW-1:0]     cm_data,
    output logic                        cm_ready,
    output logic [NBUS-1:0]             bus_valid,
    output logic [NBUS-1:0]             bus_late,
    output logic [NBUS-1:0][TAGW-1:0]   bus_tag,
    output logic [NBUS-1:0][DATAW-1:0]  bus_data
);
    import lf_pkg::*;

    localparam int CW = $clog2(NEU + NBUS + W + 1);

    logic [CW-1:0]              eu_used;
    logic [NBUS-1:0]            eu_bv, lf_bv;
    logic [NBUS-1:0][TAGW-1:0]  eu_btag, lf_btag;
    logic [NBUS-1:0][DATAW-1:0] eu_bdata, lf_bdata;
    logic [W-1:0]               cand, sent;
    logic [W-1:0][TAGW-1:0]     cand_tag;
    logic [W-1:0][DATAW-1:0]    cand_data;
    lf_src_e                    src [NBUS];

    lf_eu_arb #(.NEU(NEU), .NBUS(NBUS), .TAGW(TAGW), .DATAW(DATAW), .CW(CW)) arb_i (
        .req(eu_req), .tag(eu_tag), .data(eu_data),
        .gnt(eu_gnt), .used(eu_used),
        .bv(eu_bv), .btag(eu_btag), .bdata(eu_bdata)
    );

    lf_hold_stage #(.W(W), .TAGW(TAGW), .DATAW(DATAW)) hold_i (
        .clk(clk), .rst_n(rst_n),
        .cm_valid(cm_valid), .cm_pend(cm_pend), .cm_tag(cm_tag), .cm_data(cm_data),
        .sent(sent),
        .cand(cand), .cand_tag(cand_tag), .cand_data(cand_data),
        .cm_ready(cm_ready)
    );

    lf_late_pick #(.W(W), .NBUS(NBUS), .TAGW(TAGW), .DATAW(DATAW), .CW(CW)) pick_i (
        .cand(cand), .cand_tag(cand_tag), .cand_data(cand_data),
        .start(eu_used), .sent(sent),
        .bv(lf_bv), .btag(lf_btag), .bdata(lf_bdata)
    );

    generate
        for (genvar k = 0; k < NBUS; k++) begin : g_bus
            always_comb begin
                if (eu_bv[k])      src[k] = SRC_EU;
                else if (lf_bv[k]) src[k] = SRC_LATE;
                else               src[k] = SRC_NONE;
                bus_valid[k] = (src[k] != SRC_NONE);
                bus_late[k]  = (src[k] == SRC_LATE);
                bus_tag[k]   = (src[k] == SRC_LATE) ? lf_btag[k]  : eu_btag[k];
                bus_data[k]  = (src[k] == SRC_LATE) ? lf_bdata[k] : eu_bdata[k];
            end
        end
    endgenerate

    // R2: grant count is the lesser of requesters and buses.
    p_gnt_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eu_gnt) == (($countones(eu_req) < NBUS) ? $countones(eu_req) : NBUS));
    // R3: both sources never claim one bus.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eu_bv & lf_bv) == '0);
    // R3: a late broadcast implies every writeback request was served.
    p_eu_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|lf_bv) |-> (eu_gnt == eu_req));
    // R4: with nothing held, a late bus needs a qualifying retire entry.
    p_pend_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_ready && (|bus_late)) |-> (|(cm_valid & cm_pend)));
    // R5: one late bus per broadcast slot.
    p_late_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_late) == $countones(sent));
    // R6: an unsent qualifying entry stalls retire next cycle.
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_ready && ((cm_valid & cm_pend & ~sent) != '0)) |=> !cm_ready);
    // R8: once all held entries are out, retire reopens.
    p_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_ready && ((cand & ~sent) == '0)) |=> cm_ready);
endmodule

// File: tb/commit_late_fwd_tb_top.sv
`timescale 1ns/1ps
module commit_late_fwd_tb_top;
    localparam int W = 4, NEU = 4, NBUS = 3, TAGW = 6, DATAW = 16;
    localparam int NV = 8;
    // {eu_req, cm_valid, cm_pend, exp_gnt, exp_bus_valid, exp_bus_late, exp_stall}
    localparam logic [23:0] VEC [NV] = '{
        {4'b0000, 4'b1111, 4'b1111, 4'b0000, 3'b111, 3'b111, 2'd1},
        {4'b0101, 4'b1111, 4'b0011, 4'b0101, 3'b111, 3'b100, 2'd1},
        {4'b1111, 4'b0011, 4'b0011, 4'b0111, 3'b111, 3'b000, 2'd1},
        {4'b0000, 4'b1010, 4'b1110, 4'b0000, 3'b011, 3'b011, 2'd0},
        {4'b0010, 4'b0000, 4'b1111, 4'b0010, 3'b001, 3'b000, 2'd0},
        {4'b1000, 4'b1001, 4'b0001, 4'b1000, 3'b011, 3'b010, 2'd0},
        {4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'b000, 3'b000, 2'd0},
        {4'b0011, 4'b0111, 4'b0111, 4'b0011, 3'b111, 3'b100, 2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NEU-1:0] eu_req = '0, eu_gnt;
    logic [NEU-1:0][TAGW-1:0] eu_tag;
    logic [NEU-1:0][DATAW-1:0] eu_data;
    logic [W-1:0] cm_valid = '0, cm_pend = '0;
    logic [W-1:0][TAGW-1:0] cm_tag = '0;
    logic [W-1:0][DATAW-1:0] cm_data = '0;
    logic cm_ready;
    logic [NBUS-1:0] bus_valid, bus_late;
    logic [NBUS-1:0][TAGW-1:0] bus_tag;
    logic [NBUS-1:0][DATAW-1:0] bus_data;

    int errors = 0, checks = 0;
    int seen [64];

    always #4 clk = ~clk;

    commit_late_fwd #(.W(W), .NEU(NEU), .NBUS(NBUS), .TAGW(TAGW), .DATAW(DATAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .eu_req(eu_req), .eu_tag(eu_tag), .eu_data(eu_data),
        .eu_gnt(eu_gnt), .cm_valid(cm_valid), .cm_pend(cm_pend), .cm_tag(cm_tag),
        .cm_data(cm_data), .cm_ready(cm_ready), .bus_valid(bus_valid), .bus_late(bus_late),
        .bus_tag(bus_tag), .bus_data(bus_data)
    );

    always_comb begin
        for (int i = 0; i < NEU; i++) begin
            eu_tag[i]  = TAGW'(56 + i);
            eu_data[i] = DATAW'(16'hE000 + i);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cm(input logic [3:0] v, input logic [3:0] p, input int base);
        cm_valid = v;
        cm_pend  = p;
        for (int j = 0; j < W; j++) begin
            cm_tag[j]  = TAGW'(base + j);
            cm_data[j] = DATAW'(16'hC000 + base + j);
        end
    endtask

    task automatic record_late();
        for (int k = 0; k < NBUS; k++) begin
            if (bus_valid[k] && bus_late[k]) begin
                seen[int'(bus_tag[k])]++;
                chk(bus_data[k] == DATAW'(16'hC000 + int'(bus_tag[k])), "R5 late data",
                    int'(bus_data[k]), 16'hC000 + int'(bus_tag[k]));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int exp_tag [NBUS];
        int k, stall;
        logic [3:0] er, cv, cp, eg, qual;
        logic [2:0] ebv, ebl;
        // R1 reset state
        #2;
        chk(bus_valid == '0, "R1 bus_valid", int'(bus_valid), 0);
        chk(cm_ready == 1'b1, "R1 cm_ready", int'(cm_ready), 1);
        chk(eu_gnt == '0, "R1 eu_gnt", int'(eu_gnt), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            {er, cv, cp, eg, ebv, ebl} = VEC[n][23:2];
            for (int t = 0; t < 64; t++) seen[t] = 0;
            eu_req = er;
            set_cm(cv, cp, 8 * n);
            qual = cv & cp;
            #2;
            chk(eu_gnt == eg, "R2 grant order", int'(eu_gnt), int'(eg));
            chk(bus_valid == ebv, "R3 bus_valid", int'(bus_valid), int'(ebv));
            chk(bus_late == ebl, "R5 bus_late", int'(bus_late), int'(ebl));
            k = 0;
            for (int t = 0; t < NBUS; t++) exp_tag[t] = -1;
            for (int i = 0; i < NEU; i++) if (er[i] && k < NBUS) begin exp_tag[k] = 56 + i; k++; end
            for (int j = 0; j < W; j++) if (qual[j] && k < NBUS) begin exp_tag[k] = 8 * n + j; k++; end
            for (int t = 0; t < NBUS; t++)
                if (exp_tag[t] >= 0)
                    chk(int'(bus_tag[t]) == exp_tag[t], "R2 R5 bus tag", int'(bus_tag[t]), exp_tag[t]);
            record_late();
            // Drain: junk on retire inputs must be ignored (R6).
            stall = 0;
            @(negedge clk);
            eu_req = '0;
            while (!cm_ready && stall < 10) begin
                set_cm(4'b1111, 4'b1111, 60);
                #2;
                record_late();
                stall++;
                @(negedge clk);
            end
            set_cm(4'b0000, 4'b0000, 0);
            chk(stall == int'(VEC[n][1:0]), "R8 stall cycles", stall, int'(VEC[n][1:0]));
            for (int j = 0; j < W; j++) begin
                chk(seen[8 * n + j] == (qual[j] ? 1 : 0), "R4 R7 delivered once",
                    seen[8 * n + j], qual[j] ? 1 : 0);
                chk(seen[60 + j] == 0, "R6 stalled input ignored", seen[60 + j], 0);
            end
        end

        // Saturating writebacks starve a held group (R3, R6), then release (R7, R8).
        for (int t = 0; t < 64; t++) seen[t] = 0;
        eu_req = 4'b1111;
        set_cm(4'b0011, 4'b0011, 40);
        #2;
        chk(bus_late == '0, "R3 starved", int'(bus_late), 0);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            set_cm(4'b1111, 4'b1111, 60);
            #2;
            chk(bus_late == '0, "R3 held under saturation", int'(bus_late), 0);
            chk(cm_ready == 1'b0, "R6 stalled", int'(cm_ready), 0);
            @(negedge clk);
        end
        eu_req = 4'b0001;
        #2;
        chk(bus_late == 3'b110, "R7 retry slot order", int'(bus_late), 6);
        chk(int'(bus_tag[1]) == 40 && int'(bus_tag[2]) == 41, "R7 retry tags",
            int'(bus_tag[1]), 40);
        record_late();
        @(negedge clk);
        eu_req = '0;
        set_cm(4'b0000, 4'b0000, 0);
        #2;
        chk(cm_ready == 1'b1, "R8 reopen", int'(cm_ready), 1);
        chk(seen[40] == 1 && seen[41] == 1, "R7 once after retry", seen[40] + seen[41], 2);
        chk(seen[60] == 0, "R6 junk ignored", seen[60], 0);

        // Reset while holding (R9).
        @(negedge clk);
        set_cm(4'b1111, 4'b1111, 48);
        @(negedge clk);
        set_cm(4'b0000, 4'b0000, 0);
        #2;
        chk(cm_ready == 1'b0, "R6 held before reset", int'(cm_ready), 0);
        rst_n = 1'b0;
        #2;
        chk(cm_ready == 1'b1, "R9 reset clears hold", int'(cm_ready), 1);
        chk(bus_valid == '0, "R9 buses idle", int'(bus_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(bus_valid == '0 && cm_ready, "R9 stays idle", int'(bus_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule